// File: doc/BRIEF.md
# Graphics RAM Write-Mode Unit

A synthesizable behavioural core of a two-bank synchronous graphics RAM, scaled down through parameters. Commands arrive on active-low select, row-strobe, column-strobe and write-enable pins, sampled on the rising clock edge. A separate special-function pin (`gfx_sel`) turns three ordinary commands into graphics variants. A mode-set command becomes a load of the color or mask register. An activate command also switches on masked writing for that bank. A write command becomes an eight-column fill from the color register.

The bidirectional data bus is split into `dq_in` and `dq_out`, with `dq_oe` marking valid read data. Each bank tracks its open row and its masked-write enable. Burst length and read latency are both fixed at one. Refresh and analog timing are not modelled.

Top module: `gram_core`

## Requirements
- R1: After reset, no bank has an open row, masked writing is off in both banks, the mask register holds all ones and the color register holds zero.
- R2: With `gfx_sel` low, commands act as a plain SDRAM. The pin codes for {cs_n, ras_n, cas_n, we_n} are activate 0011, read 0101, write 0100, precharge 0010 and mode set 0000, with 1xxx as no operation. Activate opens row `addr[ROW_W-1:0]` of bank `ba`, and write stores `dq_in` at column `addr[COL_W-1:0]`. Read data appears on `dq_out`, with `dq_oe` high, in the cycle after the read command, and `dq_oe` is never high otherwise.
- R3: A mode set with `gfx_sel` high, `addr[5]` high and `addr[6]` low copies `dq_in` into the color register in that cycle.
- R4: A mode set with `gfx_sel` high and both `addr[5]` and `addr[6]` high loads the mask register from `dq_in` in the command cycle and the color register from `dq_in` in the following cycle. Any command presented during that following cycle is ignored.
- R5: A special register load may be issued while rows are open, and it leaves every open row open.
- R6: An activate with `gfx_sel` high turns masked writing on for the addressed bank only. An activate with `gfx_sel` low turns it off for that bank. The other bank keeps its setting.
- R7: A write to a bank with masked writing on keeps the stored value of every bit whose mask bit is 0. Bits whose mask bit is 1 take the new data.
- R8: A write with `gfx_sel` high is a block write to columns base..base+7, where base is the column address with its 3 low bits cleared. Column base+i is written with the color register when `dq_in[i]` is 1 and left unchanged when it is 0.
- R9: A block write to a bank with masked writing on applies the mask register to every enabled column.
- R10: Reads and writes to a bank with no open row have no effect (no `dq_oe`, no stored change), and precharge closes the addressed bank's row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| gfx_sel | input | 1 | Special-function select |
| ba | input | 1 | Bank address |
| addr | input | ADDR_W (8) | Row, column or load-select address |
| dq_in | input | DATA_W (32) | Data bus, inbound half |
| dq_out | output | DATA_W (32) | Data bus, outbound half |
| dq_oe | output | 1 | Read data valid / bus drive enable |

## Verification
The hardest case to reach is the second cycle of a dual register load that carries a live command. The block must latch the data as color while discarding the command, and only a write to an open bank shows that the command was discarded. The bench sets this up on purpose by placing a write to an open row in that cycle, then reading the location back. The random phase also issues dual loads with arbitrary trailing commands. Masked block writes combine three pieces of state: per-bank enable, mask and color. Random stimulus reaches them by interleaving activates with random `gfx_sel` and register loads, and a shadow model computes the expected contents.

// File: rtl/gram_pkg.sv
package gram_pkg;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_ACT,
        OP_RD,
        OP_WR,
        OP_PRE,
        OP_SPC
    } gram_op_e;

    typedef struct packed {
        gram_op_e op;
        logic     gfx;
    } gram_cmd_t;

    // Block fill geometry: eight columns, aligned
    localparam int BLK_COLS = 8;
    localparam int BLK_LOG  = 3;

    // Address bits selecting which special register a load touches
    localparam int SEL_COLOR_BIT = 5;
    localparam int SEL_MASK_BIT  = 6;

    function automatic gram_op_e pins_to_op(logic cs_n, logic ras_n,
                                            logic cas_n, logic we_n);
        if (cs_n) return OP_NOP;
        case ({ras_n, cas_n, we_n})
            3'b011:  return OP_ACT;
            3'b101:  return OP_RD;
            3'b100:  return OP_WR;
            3'b010:  return OP_PRE;
            3'b000:  return OP_SPC;
            default: return OP_NOP;
        endcase
    endfunction

endpackage

// File: rtl/gram_cmd_decode.sv
module gram_cmd_decode
    import gram_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    input  logic      gfx_sel,
    input  logic      hold,
    output gram_cmd_t cmd
);
    always_comb begin
        cmd.op  = hold ? OP_NOP : pins_to_op(cs_n, ras_n, cas_n, we_n);
        cmd.gfx = gfx_sel;
    end
endmodule

// File: rtl/gram_bank_state.sv
module gram_bank_state
    import gram_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int ROW_W = 3,
    localparam int BA_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  gram_cmd_t                   cmd,
    input  logic [BA_W-1:0]             ba,
    input  logic [ROW_W-1:0]            row_in,
    output logic [NBANK-1:0]            open_o,
    output logic [NBANK-1:0][ROW_W-1:0] row_o,
    output logic [NBANK-1:0]            wpb_o
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_o[b] <= 1'b0;
                row_o[b]  <= '0;
                wpb_o[b]  <= 1'b0;
            end else if (hit) begin
                if (cmd.op == OP_ACT) begin
                    open_o[b] <= 1'b1;
                    row_o[b]  <= row_in;
                    wpb_o[b]  <= cmd.gfx;
                end else if (cmd.op == OP_PRE) begin
                    open_o[b] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/gram_special_regs.sv
module gram_special_regs
    import gram_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  gram_cmd_t         cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] color,
    output logic [DATA_W-1:0] mask,
    output logic              busy
);
    logic is_load;
    assign is_load = (cmd.op == OP_SPC) && cmd.gfx && addr[SEL_COLOR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            color <= '0;
            mask  <= '1;
            busy  <= 1'b0;
        end else if (busy) begin
            color <= din;
            busy  <= 1'b0;
        end else if (is_load) begin
            if (addr[SEL_MASK_BIT]) begin
                mask <= din;
                busy <= 1'b1;
            end else begin
                color <= din;
            end
        end
    end
endmodule

// File: rtl/gram_array.sv
module gram_array
    import gram_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 5,
    parameter int DATA_W = 32,
    localparam int BA_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int IDX_W = BA_W + ROW_W + COL_W,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  gram_cmd_t                   cmd,
    input  logic [BA_W-1:0]             ba,
    input  logic [COL_W-1:0]            col,
    input  logic [DATA_W-1:0]           din,
    input  logic [NBANK-1:0]            bank_open,
    input  logic [NBANK-1:0][ROW_W-1:0] bank_row,
    input  logic [NBANK-1:0]            wpb,
    input  logic [DATA_W-1:0]           color,
    input  logic [DATA_W-1:0]           mask,
    output logic [DATA_W-1:0]           rdata,
    output logic                        rvalid
);
    logic [DATA_W-1:0] mem [DEPTH];

    logic               sel_open;
    logic [ROW_W-1:0]   sel_row;
    logic [DATA_W-1:0]  wmask;
    logic [COL_W-1:0]   base;

    function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old_v,
                                                logic [DATA_W-1:0] new_v,
                                                logic [DATA_W-1:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

    always_comb begin
        sel_open = bank_open[ba];
        sel_row  = bank_row[ba];
        wmask    = wpb[ba] ? mask : '1;
        base     = {col[COL_W-1:BLK_LOG], BLK_LOG'(0)};
    end

    always_ff @(posedge clk) begin
        if (sel_open && cmd.op == OP_WR) begin
            if (!cmd.gfx) begin
                mem[{ba, sel_row, col}] <= merge(mem[{ba, sel_row, col}], din, wmask);
            end else begin
                for (int i = 0; i < BLK_COLS; i++) begin
                    if (din[i]) begin
                        mem[{ba, sel_row, base | COL_W'(i)}] <=
                            merge(mem[{ba, sel_row, base | COL_W'(i)}], color, wmask);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= sel_open && (cmd.op == OP_RD);
            if (sel_open && cmd.op == OP_RD) begin
                rdata <= mem[{ba, sel_row, col}];
            end
        end
    end
endmodule

// File: rtl/gram_core.sv
module gram_core
    import gram_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int BA_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              gfx_sel,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    gram_cmd_t                   cmd;
    logic                        busy;
    logic [DATA_W-1:0]           color;
    logic [DATA_W-1:0]           mask;
    logic [NBANK-1:0]            bank_open;
    logic [NBANK-1:0][ROW_W-1:0] bank_row;
    logic [NBANK-1:0]            wpb;

    gram_cmd_decode u_dec (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .gfx_sel (gfx_sel),
        .hold    (busy),
        .cmd     (cmd)
    );

    gram_bank_state #(.NBANK(NBANK), .ROW_W(ROW_W)) u_banks (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .ba     (ba),
        .row_in (addr[ROW_W-1:0]),
        .open_o (bank_open),
        .row_o  (bank_row),
        .wpb_o  (wpb)
    );

    gram_special_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .addr  (addr),
        .din   (dq_in),
        .color (color),
        .mask  (mask),
        .busy  (busy)
    );

    gram_array #(.NBANK(NBANK), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .ba        (ba),
        .col       (addr[COL_W-1:0]),
        .din       (dq_in),
        .bank_open (bank_open),
        .bank_row  (bank_row),
        .wpb       (wpb),
        .color     (color),
        .mask      (mask),
        .rdata     (dq_out),
        .rvalid    (dq_oe)
    );
endmodule

// File: rtl/gram_core_chk.sv
module gram_core_chk #(
    parameter int NBANK  = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int BA_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              gfx_sel,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dq_in,
    input logic              dq_oe,
    input logic              busy,
    input logic [DATA_W-1:0] color,
    input logic [DATA_W-1:0] mask,
    input logic [NBANK-1:0]  bank_open,
    input logic [NBANK-1:0]  wpb
);
    logic is_spc, is_act, is_rd;
    assign is_spc = !cs_n && !ras_n && !cas_n && !we_n && !busy;
    assign is_act = !cs_n && !ras_n &&  cas_n &&  we_n && !busy;
    assign is_rd  = !cs_n &&  ras_n && !cas_n &&  we_n;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask == '1 && color == '0 && bank_open == '0 && wpb == '0));

    // R2
    oe_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> $past(is_rd && !busy));

    // R3
    color_load_chk: assert property (@(posedge clk) disable iff (rst)
        (is_spc && gfx_sel && addr[5] && !addr[6]) |=> (color == $past(dq_in)));

    // R4
    dual_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (is_spc && gfx_sel && addr[5] && addr[6]) |=> (busy && mask == $past(dq_in)));

    // R4
    dual_color_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy && color == $past(dq_in) && $stable(mask)));

    // R5
    load_keeps_rows_chk: assert property (@(posedge clk) disable iff (rst)
        (is_spc && gfx_sel) |=> $stable(bank_open));

    // R6
    wpb_set_chk: assert property (@(posedge clk) disable iff (rst)
        (is_act && gfx_sel) |=>
        (wpb[$past(ba)] && ((wpb ^ $past(wpb)) & ~(NBANK'(1) << $past(ba))) == '0));

    // R6
    wpb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (is_act && !gfx_sel) |=> !wpb[$past(ba)]);

    // R10
    closed_read_chk: assert property (@(posedge clk) disable iff (rst)
        (is_rd && !busy && !bank_open[ba]) |=> !dq_oe);
endmodule

bind gram_core gram_core_chk #(.NBANK(NBANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .gfx_sel   (gfx_sel),
    .ba        (ba),
    .addr      (addr),
    .dq_in     (dq_in),
    .dq_oe     (dq_oe),
    .busy      (busy),
    .color     (color),
    .mask      (mask),
    .bank_open (bank_open),
    .wpb       (wpb)
);

// File: tb/sim_gram_core.sv
module sim_gram_core;
    localparam int ROWS = 8;
    localparam int COLS = 32;
    localparam logic [3:0] C_NOP = 4'b1111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_SPC = 4'b0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, ras_n, cas_n, we_n, gfx_sel;
    logic [0:0]  ba;
    logic [7:0]  addr;
    logic [31:0] dq_in;
    logic [31:0] dq_out;
    logic        dq_oe;

    always #5 clk = ~clk;

    gram_core u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .gfx_sel(gfx_sel), .ba(ba), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // shadow model
    logic [31:0] sh_mem [2][ROWS][COLS];
    logic        sh_open [2];
    logic [2:0]  sh_row  [2];
    logic        sh_wpb  [2];
    logic [31:0] sh_color, sh_mask;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [31:0] m);
        return (o & ~m) | (n & m);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pins(logic [3:0] c, logic g, logic b, logic [7:0] a, logic [31:0] q);
        {cs_n, ras_n, cas_n, we_n} = c;
        gfx_sel = g; ba = b; addr = a; dq_in = q;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
    endtask

    task automatic act(logic b, logic [2:0] r, logic g);
        pins(C_ACT, g, b, {5'd0, r}, $urandom);
        sh_open[b] = 1'b1; sh_row[b] = r; sh_wpb[b] = g;
    endtask

    task automatic pre(logic b);
        pins(C_PRE, 1'b0, b, 8'd0, $urandom);
        sh_open[b] = 1'b0;
    endtask

    task automatic model_wr(logic b, logic [4:0] c, logic [31:0] q, logic g);
        logic [31:0] m;
        if (!sh_open[b]) return;
        m = sh_wpb[b] ? sh_mask : '1;
        if (!g) begin
            sh_mem[b][sh_row[b]][c] = merge(sh_mem[b][sh_row[b]][c], q, m);
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (q[i]) sh_mem[b][sh_row[b]][{c[4:3], 3'(i)}] =
                    merge(sh_mem[b][sh_row[b]][{c[4:3], 3'(i)}], sh_color, m);
            end
        end
    endtask

    task automatic wr(logic b, logic [4:0] c, logic [31:0] q, logic g);
        pins(C_WR, g, b, {3'd0, c}, q);
        model_wr(b, c, q, g);
    endtask

    task automatic rd(logic b, logic [4:0] c, string req);
        pins(C_RD, 1'b0, b, {3'd0, c}, $urandom);
        check(dq_oe == sh_open[b], req, {31'd0, dq_oe}, {31'd0, sh_open[b]});
        if (sh_open[b])
            check(dq_out == sh_mem[b][sh_row[b]][c], req, dq_out, sh_mem[b][sh_row[b]][c]);
    endtask

    // special load; in the second cycle of a dual load drive command c2
    task automatic spc(logic a5, logic a6, logic [31:0] q1, logic [31:0] q2,
                       logic [3:0] c2, logic b2, logic [7:0] a2);
        pins(C_SPC, 1'b1, 1'b0, {1'b0, a6, a5, 5'd0}, q1);
        if (a5 && a6) begin
            sh_mask = q1;
            pins(c2, 1'b0, b2, a2, q2);
            sh_color = q2;
        end else if (a5) begin
            sh_color = q1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        gfx_sel = 0; ba = 0; addr = 0; dq_in = 0;
        sh_color = '0; sh_mask = '1;
        for (int b = 0; b < 2; b++) begin
            sh_open[b] = 0; sh_row[b] = 0; sh_wpb[b] = 0;
        end
        repeat (3) @(negedge clk);
        check(dq_oe == 1'b0, "R1 oe in reset", {31'd0, dq_oe}, 32'd0);
        rst = 1'b0;

        // R1 / R10: read with no open row gives nothing
        rd(1'b0, 5'd0, "R1 closed after reset");
        rd(1'b1, 5'd7, "R10 closed read");

        // fill all locations with normal writes (R2)
        for (int b = 0; b < 2; b++) begin
            for (int r = 0; r < ROWS; r++) begin
                act(1'(b), 3'(r), 1'b0);
                for (int c = 0; c < COLS; c++) wr(1'(b), 5'(c), $urandom, 1'b0);
            end
        end
        rd(1'b0, 5'd3, "R2 read after fill");
        rd(1'b1, 5'd31, "R2 read after fill");

        // R1: mask all ones -> masked-mode write is full
        act(1'b0, 3'd2, 1'b1);
        wr(1'b0, 5'd1, 32'hDEADBEEF, 1'b0);
        rd(1'b0, 5'd1, "R1 mask reset ones");
        check(sh_mem[0][2][1] == 32'hDEADBEEF, "R1 model", sh_mem[0][2][1], 32'hDEADBEEF);
        // R1: color zero -> block write clears
        wr(1'b0, 5'd2, 32'h0000_00FF, 1'b1);
        rd(1'b0, 5'd5, "R1 color reset zero");
        check(sh_mem[0][2][5] == 32'd0, "R1 model", sh_mem[0][2][5], 32'd0);

        // R3 color load then R8 block write with sparse enables at col 13
        act(1'b1, 3'd4, 1'b0);
        spc(1'b1, 1'b0, 32'hA5A5_1234, 32'd0, C_NOP, 1'b0, 8'd0);
        wr(1'b1, 5'd13, 32'hFFFF_FFA5, 1'b1);
        for (int c = 8; c < 16; c++) rd(1'b1, 5'(c), "R8 block enables");
        rd(1'b1, 5'd16, "R8 outside block");

        // R4 dual load; write presented in busy cycle must be ignored
        spc(1'b1, 1'b1, 32'h0F0F_0F0F, 32'h1357_9BDF, C_WR, 1'b1, 8'd20);
        rd(1'b1, 5'd20, "R4 busy command ignored");
        // R5: rows still open after loads
        rd(1'b0, 5'd1, "R5 row open after load");

        // R6/R7: bank0 masked, bank1 not
        act(1'b0, 3'd6, 1'b1);
        act(1'b1, 3'd6, 1'b0);
        wr(1'b0, 5'd9, 32'hFFFF_FFFF, 1'b0);
        wr(1'b1, 5'd9, 32'hFFFF_FFFF, 1'b0);
        rd(1'b0, 5'd9, "R7 masked write");
        rd(1'b1, 5'd9, "R6 other bank unmasked");
        // R9 masked block write
        wr(1'b0, 5'd30, 32'h0000_00F3, 1'b1);
        for (int c = 24; c < 32; c++) rd(1'b0, 5'(c), "R9 masked block");
        // R6: reactivation without gfx_sel clears masking
        act(1'b0, 3'd6, 1'b0);
        wr(1'b0, 5'd10, 32'h0000_0000, 1'b0);
        rd(1'b0, 5'd10, "R6 mask cleared");

        // R10: precharge, ignored write, reopen and read
        pre(1'b1);
        rd(1'b1, 5'd4, "R10 read after precharge");
        wr(1'b1, 5'd4, 32'h5555_AAAA, 1'b0);
        act(1'b1, 3'd6, 1'b0);
        rd(1'b1, 5'd4, "R10 write ignored");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic b;
            sel = $urandom_range(0, 11);
            b = 1'($urandom);
            case (sel)
                0, 1:    act(b, 3'($urandom), 1'($urandom));
                2:       pre(b);
                3, 4:    wr(b, 5'($urandom), $urandom, 1'b0);
                5, 6:    wr(b, 5'($urandom), $urandom, 1'b1);
                7, 8, 9: rd(b, 5'($urandom), "R7 R8 R9 random read");
                10:      spc(1'b1, 1'b0, $urandom, 32'd0, C_NOP, 1'b0, 8'd0);
                default: spc(1'b1, 1'b1, $urandom, $urandom,
                             ($urandom_range(0, 1) == 0) ? C_WR : C_ACT,
                             b, 8'($urandom));
            endcase
        end
        for (int b = 0; b < 2; b++) begin
            if (!sh_open[b]) act(1'(b), 3'd0, 1'b0);
            for (int c = 0; c < COLS; c++) rd(1'(b), 5'(c), "R2 final sweep");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule